// File: doc/BRIEF.md
# Programmable-Vector Transmit Word Packer

This block sits between a transmit FIFO of 32-bit entries and a serial shifter. It cuts each entry into protocol words. Four programmable extraction vectors control the cut. Each vector names a starting bit, a walking direction, a segment length of one to eight bits and an end-of-entry flag. The block handles one vector per clock cycle. It appends each vector's segment to a word under construction. When the collected bit count reaches the programmed bits-per-word, it presents the word and its width on a valid/ready output.

Software loads the vectors and the bits-per-word through a small write port while no entry is in flight. With suitable settings the same datapath serves four 8-bit words per entry, two 16-bit words per entry, or one word of up to 32 bits. Words may be sent LSB first or MSB first. The entry is released to the FIFO only when the word carrying its last segment is accepted. The next entry starts again from vector 0.

Top module: `wp_packer`

## Requirements
- R1: After reset, outValid and inReady are low while inValid is low. All vectors read as start 0, length 1, LSB first, stop clear, and bits-per-word equals RESET_BPW. With that state, the entry 0x00000001 gives one word 0xF of width 4, on the fourth processing cycle.
- R2: A write with cfgAddr 0 loads vector 0 from cfgData[9:0] and vector 1 from cfgData[19:10]. cfgAddr 1 loads vectors 2 and 3 the same way. cfgAddr 2 loads bits-per-word from cfgData[5:0]. Within a vector, bits 9:5 hold the start index, bit 4 selects MSB-first walking, bits 3:1 hold the length minus one, and bit 0 is the stop flag.
- R3: An LSB-first vector takes entry bits start up to start+len-1. The lowest of these lands at the lowest free position of the word under construction. Positions above bit 31 read as zero.
- R4: An MSB-first vector takes entry bits start down to start-len+1. The word built so far shifts up by len, and the segment fills the low bits. Positions below bit 0 read as zero.
- R5: Exactly one vector is processed per advancing cycle. A word is offered as soon as the collected count reaches or exceeds bits-per-word. outWidth equals the collected count, and the next word starts empty.
- R6: A vector with stop set is the last one for its entry. Whatever has been collected is offered as a word even if it is shorter than bits-per-word. inReady is high only in the cycle that word is accepted, and the next entry begins at vector 0.
- R7: If none of vectors 0 to 2 has stop set, vector 3 is treated as the last one.
- R8: While outValid is high and outReady is low, outWord and outWidth hold, no vector is consumed and inReady stays low.
- R9: The vector settings for 4x8 MSB-first 7-bit words, 2x16 LSB-first 15-bit words and 1x32 MSB-first 23-bit words produce the entry's words in transmit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration target: 0 vectors 0/1, 1 vectors 2/3, 2 bits-per-word |
| cfgData | input | 20 | Configuration write data |
| inValid | input | 1 | FIFO entry present |
| inReady | output | 1 | Entry consumed (pop) |
| inData | input | 32 | FIFO entry |
| outValid | output | 1 | Protocol word present |
| outReady | input | 1 | Shifter accepts the word |
| outWord | output | 32 | Protocol word, right-aligned |
| outWidth | output | 6 | Number of valid bits in outWord |

## Verification
The bench builds the packer with the default RESET_BPW of 8 and the fixed 32-bit entry and four-vector shape. This leaves the reset vector state observable: four single-bit segments taken from bit 0 and flushed by the implicit last vector. Every vector position, both walking directions and segments that run past either end of the entry can be reached with single entries. Back-to-back entries and stalls on both a middle word and the final word exercise the pop timing and the restart at vector 0.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int ENTRY_W = 32;
  localparam int NUM_VEC = 4;
  localparam int SEG_MAX = 8;
  localparam int IDX_W   = $clog2(ENTRY_W);
  localparam int LEN_W   = $clog2(SEG_MAX);
  localparam int VEC_W   = IDX_W + LEN_W + 2;
  localparam int CFG_W   = 2 * VEC_W;
  localparam int CNT_W   = $clog2(ENTRY_W) + 1;
  localparam int VSEL_W  = $clog2(NUM_VEC);
  localparam int ADDR_W  = 2;

  typedef struct packed {
    logic [IDX_W-1:0] start;
    logic             msbFirst;
    logic [LEN_W-1:0] lenM1;
    logic             stop;
  } vec_t;

  typedef struct packed {
    logic advance;   // consume the current vector
    logic clearAcc;  // word handed off, start empty
    logic pop;       // entry finished
  } ctrl_t;
endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int RESET_BPW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [VSEL_W-1:0]  vecIdx,
  input  ctrl_t              ctrl,
  output logic               emit,
  output logic               last,
  output logic [ENTRY_W-1:0] newWord,
  output logic [CNT_W-1:0]   newCnt
);
  localparam int EXT_W = ENTRY_W + SEG_MAX - 1;

  vec_t               vecs [NUM_VEC];
  logic [CNT_W-1:0]   bpw;
  logic [ENTRY_W-1:0] acc;
  logic [CNT_W-1:0]   cnt;

  vec_t               cur;
  logic [CNT_W-1:0]   segLen;
  logic [CNT_W-1:0]   msbShift;
  logic [ENTRY_W-1:0] mask;
  logic [ENTRY_W-1:0] lsbSeg;
  logic [ENTRY_W-1:0] msbSeg;
  logic [ENTRY_W-1:0] seg;
  logic [EXT_W-1:0]   ext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int v = 0; v < NUM_VEC; v++) vecs[v] <= '0;
      bpw <= CNT_W'(RESET_BPW);
    end else if (cfgWe) begin
      for (int p = 0; p < NUM_VEC / 2; p++) begin
        if (cfgAddr == ADDR_W'(p)) begin
          vecs[2*p]   <= vec_t'(cfgData[VEC_W-1:0]);
          vecs[2*p+1] <= vec_t'(cfgData[CFG_W-1:VEC_W]);
        end
      end
      if (cfgAddr == ADDR_W'(NUM_VEC / 2)) bpw <= cfgData[CNT_W-1:0];
    end
  end

  always_comb begin
    cur      = vecs[vecIdx];
    segLen   = CNT_W'(cur.lenM1) + CNT_W'(1);
    mask     = (ENTRY_W'(1) << segLen) - ENTRY_W'(1);
    lsbSeg   = (entry >> cur.start) & mask;
    ext      = {entry, {(SEG_MAX-1){1'b0}}};
    msbShift = CNT_W'(cur.start) + CNT_W'(SEG_MAX) - segLen;
    msbSeg   = ENTRY_W'(ext >> msbShift) & mask;
    seg      = cur.msbFirst ? msbSeg : lsbSeg;
    newWord  = cur.msbFirst ? ((acc << segLen) | seg) : (acc | (seg << cnt));
    newCnt   = cnt + segLen;
    last     = cur.stop || (vecIdx == VSEL_W'(NUM_VEC - 1));
    emit     = (newCnt >= bpw) || last;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
      cnt <= '0;
    end else if (ctrl.advance) begin
      if (ctrl.clearAcc) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= newWord;
        cnt <= newCnt;
      end
    end
  end
endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              outReady,
  input  logic              emit,
  input  logic              last,
  output logic [VSEL_W-1:0] vecIdx,
  output ctrl_t             ctrl,
  output logic              outValid,
  output logic              inReady
);
  always_comb begin
    ctrl.advance  = inValid && (!emit || outReady);
    ctrl.clearAcc = ctrl.advance && emit;
    ctrl.pop      = ctrl.advance && last;
    outValid      = inValid && emit;
    inReady       = ctrl.pop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vecIdx <= '0;
    else if (ctrl.advance) vecIdx <= last ? '0 : vecIdx + VSEL_W'(1);
  end
endmodule

// File: rtl/wp_packer.sv
module wp_packer
  import wp_pkg::*;
#(
  parameter int RESET_BPW = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  input  logic               inValid,
  output logic               inReady,
  input  logic [ENTRY_W-1:0] inData,
  output logic               outValid,
  input  logic               outReady,
  output logic [ENTRY_W-1:0] outWord,
  output logic [CNT_W-1:0]   outWidth
);
  logic [VSEL_W-1:0] vecIdx;
  ctrl_t             ctrl;
  logic              emit;
  logic              last;

  wp_control u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .emit(emit), .last(last), .vecIdx(vecIdx), .ctrl(ctrl),
    .outValid(outValid), .inReady(inReady)
  );

  wp_datapath #(.RESET_BPW(RESET_BPW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .entry(inData), .vecIdx(vecIdx), .ctrl(ctrl),
    .emit(emit), .last(last), .newWord(outWord), .newCnt(outWidth)
  );
endmodule

// File: rtl/wp_checker.sv
module wp_checker
  import wp_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               cfgWe,
  input logic               inValid,
  input logic               inReady,
  input logic [ENTRY_W-1:0] inData,
  input logic               outValid,
  input logic               outReady,
  input logic [ENTRY_W-1:0] outWord,
  input logic [CNT_W-1:0]   outWidth
);
  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !cfgWe) |=>
      (!inValid || !$stable(inData) || (outValid && $stable(outWord) && $stable(outWidth))));

  // R8
  no_pop_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // R6
  pop_on_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (inValid && outValid && outReady));

  // R5
  width_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outWidth != '0 && outWidth <= CNT_W'(ENTRY_W)));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (!outValid && !inReady));
endmodule

bind wp_packer wp_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .inValid(inValid), .inReady(inReady),
  .inData(inData), .outValid(outValid), .outReady(outReady),
  .outWord(outWord), .outWidth(outWidth)
);

// File: tb/wp_packer_tb.sv
`timescale 1ns/1ps
module wp_packer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [19:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [31:0] outWord;
  logic [5:0]  outWidth;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wp_packer u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outWord(outWord), .outWidth(outWidth)
  );

  typedef struct packed {
    logic [19:0]       c01;
    logic [19:0]       c23;
    logic [5:0]        bpw;
    logic [31:0]       ent;
    logic [2:0]        n;
    logic [0:3][31:0]  w;
    logic [0:3][5:0]   wd;
    logic [7:0]        req;
  } row_t;

  // vector = start<<5 | msbFirst<<4 | (len-1)<<1 | stop   (R2)
  localparam row_t ROWS [8] = '{
    // R3 4x8 LSB first, stop on vector 3
    '{20'h4380E, 20'hC3E0E, 6'd8,  32'hA1B2C3D4, 3'd4,
      {32'hD4, 32'hC3, 32'hB2, 32'hA1}, {6'd8, 6'd8, 6'd8, 6'd8}, 8'd3},
    // R9 2x16 LSB first, 15-bit words
    '{20'h4300E, 20'hC360E, 6'd15, 32'hF234D678, 3'd2,
      {32'h5678, 32'h7234, 32'h0, 32'h0}, {6'd15, 6'd15, 6'd0, 6'd0}, 8'd9},
    // R9 1x32 MSB first, 23-bit word, stop on vector 2
    '{20'h77ADE, 20'h000DD, 6'd23, 32'hFFABCDEF, 3'd1,
      {32'h2BCDEF, 32'h0, 32'h0, 32'h0}, {6'd23, 6'd0, 6'd0, 6'd0}, 8'd9},
    // R9 4x8 MSB first, 7-bit words
    '{20'h770DC, 20'hF76DC, 6'd7,  32'h81828384, 3'd4,
      {32'h04, 32'h03, 32'h02, 32'h01}, {6'd7, 6'd7, 6'd7, 6'd7}, 8'd9},
    // R7 no stop anywhere, 16-bit words
    '{20'h4380E, 20'hC3A0E, 6'd16, 32'hCAFEBABE, 3'd2,
      {32'hBABE, 32'hCAFE, 32'h0, 32'h0}, {6'd16, 6'd16, 6'd0, 6'd0}, 8'd7},
    // R6 stop on vector 1 flushes a short word
    '{20'h43C0E, 20'hC3E0E, 6'd32, 32'h11223344, 3'd1,
      {32'h3344, 32'h0, 32'h0, 32'h0}, {6'd16, 6'd0, 6'd0, 6'd0}, 8'd6},
    // R3 segment past bit 31 reads zeros
    '{20'h0038F, 20'h00000, 6'd8,  32'hA0000000, 3'd1,
      {32'h0A, 32'h0, 32'h0, 32'h0}, {6'd8, 6'd0, 6'd0, 6'd0}, 8'd3},
    // R4 segment below bit 0 reads zeros
    '{20'h0005F, 20'h00000, 6'd8,  32'h00000005, 3'd1,
      {32'hA0, 32'h0, 32'h0, 32'h0}, {6'd8, 6'd0, 6'd0, 6'd0}, 8'd4}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [1:0] a, input logic [19:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic waitWord();
    int g = 0;
    #1;
    while (!outValid && g < 10) begin
      @(negedge clk);
      #1;
      g++;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 outValid", 32'(outValid), 32'd0);
    chk("R1 inReady", 32'(inReady), 32'd0);

    // R1 default vectors: four 1-bit segments from bit 0, vector 3 last
    @(negedge clk);
    inValid = 1'b1; inData = 32'h00000001; outReady = 1'b1;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R1 no word yet", 32'(outValid), 32'd0);
      @(negedge clk);
    end
    #1;
    chk("R1 word", outWord, 32'hF);
    chk("R1 width", 32'(outWidth), 32'd4);
    chk("R1 pop", 32'(inReady), 32'd1);
    @(negedge clk);
    inValid = 1'b0;

    // table walk (R2 config decode used by every row)
    for (int i = 0; i < 8; i++) begin
      cfgWr(2'd0, ROWS[i].c01);
      cfgWr(2'd1, ROWS[i].c23);
      cfgWr(2'd2, 20'(ROWS[i].bpw));
      @(negedge clk);
      inValid = 1'b1; inData = ROWS[i].ent; outReady = 1'b1;
      for (int k = 0; k < int'(ROWS[i].n); k++) begin
        waitWord();
        chk($sformatf("R%0d row%0d word%0d", ROWS[i].req, i, k), outWord, ROWS[i].w[k]);
        chk($sformatf("R%0d row%0d width%0d", ROWS[i].req, i, k), 32'(outWidth), 32'(ROWS[i].wd[k]));
        chk($sformatf("R%0d row%0d pop%0d", ROWS[i].req, i, k), 32'(inReady),
            (k == int'(ROWS[i].n) - 1) ? 32'd1 : 32'd0);
        @(negedge clk);
      end
      inValid = 1'b0;
    end

    // R8 backpressure on first and last word, R5 one vector per cycle
    cfgWr(2'd0, 20'h4380E);
    cfgWr(2'd1, 20'hC3E0E);
    cfgWr(2'd2, 20'd8);
    @(negedge clk);
    inValid = 1'b1; inData = 32'hA1B2C3D4; outReady = 1'b0;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk("R8 held word", outWord, 32'hD4);
      chk("R8 held width", 32'(outWidth), 32'd8);
      chk("R8 no pop", 32'(inReady), 32'd0);
      @(negedge clk);
    end
    outReady = 1'b1;
    #1;
    chk("R8 release", outWord, 32'hD4);
    @(negedge clk);
    #1;
    chk("R5 next vector", outWord, 32'hC3);
    @(negedge clk);
    @(negedge clk);
    outReady = 1'b0;
    #1;
    chk("R8 last held", outWord, 32'hA1);
    chk("R8 last no pop", 32'(inReady), 32'd0);
    @(negedge clk);
    #1;
    chk("R8 last still held", outWord, 32'hA1);
    outReady = 1'b1;
    #1;
    chk("R6 pop on accept", 32'(inReady), 32'd1);
    @(negedge clk);
    inValid = 1'b0;

    // R6 back-to-back entries restart at vector 0
    @(negedge clk);
    inValid = 1'b1; inData = 32'h01020304; outReady = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (k == 4) inData = 32'h05060708;
      #1;
      chk("R6 stream word", outWord,
          (k < 4) ? 32'(4 - k) : 32'(12 - k));
      chk("R6 stream pop", 32'(inReady), (k == 3 || k == 7) ? 32'd1 : 32'd0);
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule